// File: doc/BRIEF.md
# Manual Reset Pulse Timer

This block supervises a push-button or board-level manual reset line. It turns that line into a reset pulse whose length comes from an internal cycle counter. It reacts only to the moment the line becomes active. A static polarity pin sets which transition counts: a rising transition when the line is active-high, a falling transition when it is active-low. From that transition the block drives a pair of complementary reset outputs for a fixed number of clock cycles. The default is 10,000,000 cycles, which is 200 ms at 50 MHz.

The pulse length is set by the counter alone. Holding the manual line active does not stretch the reset outputs. The block also drives a separate memory-block output. This output stays asserted while the reset pulse runs and also while the synchronized manual line is held active. A stuck button therefore keeps an attached memory from answering accesses, while the rest of the system leaves reset on time. A fresh active transition during a running pulse starts the full count again. At power-on the pulse is already active and runs one full count before it releases.

Top module: `manual_reset_timer`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1, `rst_out_n` is 0 and `mem_block` is 1. With the manual line inactive, `rst_out` returns to 0 at the TIMEOUT_CYCLES-th rising clock edge after `rst_n` goes high.
- R2: With `pol_high`=1, a 0-to-1 change of `man_in` first sampled at rising edge k sets `rst_out` to 1 from edge k+2 through edge k+TIMEOUT_CYCLES+1. It is 0 again at edge k+TIMEOUT_CYCLES+2.
- R3: With `pol_high`=0, a 1-to-0 change of `man_in` gives the same timing as R2.
- R4: A change of `man_in` from its active level to its inactive level starts no pulse, and neither does a level held steady. When idle, `rst_out` stays 0.
- R5: `rst_out_n` is always the inverse of `rst_out`.
- R6: If `man_in` stays at its active level longer than TIMEOUT_CYCLES cycles, `rst_out` still returns to 0 after TIMEOUT_CYCLES cycles.
- R7: `mem_block` is 1 whenever `rst_out` is 1 or the synchronized manual level is active. It therefore stays 1 while `man_in` is held active past the pulse, and it returns to 0 two rising edges after the line is released.
- R8: An active transition that arrives while a pulse is running restarts the count. `rst_out` stays 1 until TIMEOUT_CYCLES cycles after the new transition, following the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pol_high | input | 1 | Static polarity: 1 = manual line active high, 0 = active low |
| man_in | input | 1 | Asynchronous manual reset line |
| rst_out | output | 1 | Reset pulse, active high |
| rst_out_n | output | 1 | Reset pulse, active low |
| mem_block | output | 1 | Memory access block: pulse running or manual line held |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 20 and SYNC_STAGES set to 2. Holding the line well past the timeout, retriggering mid-pulse and several full pulses in both polarities then fit within a few hundred cycles. The short count puts the pulse end, the hold-beyond-timeout case and the restart window all inside one run, so every cycle can be compared against the behavioural model. Both polarities are covered by changing `pol_high` under power-on reset.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  // Counter width needed to hold a terminal count of 'limit'.
  function automatic int cnt_bits(input longint limit);
    int b;
    b = 1;
    while ((longint'(1) << b) <= limit) b++;
    return b;
  endfunction

  // Next value of the remaining-cycle counter: reload on a trigger,
  // otherwise count down and rest at zero.
  function automatic longint next_remaining(input longint cur,
                                            input bit     load,
                                            input longint limit);
    if (load)         return limit;
    else if (cur > 0) return cur - 1;
    else              return 0;
  endfunction

  // Active-level normalisation of the raw manual line.
  function automatic logic active_level(input logic raw, input logic pol_hi);
    return pol_hi ? raw : ~raw;
  endfunction

endpackage

// File: rtl/mrt_sync.sv
module mrt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], din};
      end
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/mrt_edge.sv
module mrt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fire
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign fire = lvl & ~lvl_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R4
endmodule

// File: rtl/mrt_timer.sv
module mrt_timer #(
  parameter longint TIMEOUT = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  import mrt_pkg::*;

  localparam int         CW   = cnt_bits(TIMEOUT);
  localparam logic [CW-1:0] FULL = CW'(TIMEOUT);

  logic [CW-1:0] remain;
  logic [CW-1:0] remain_nx;

  always_comb begin
    remain_nx = CW'(next_remaining(longint'(remain), load, TIMEOUT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= FULL;
    else        remain <= remain_nx;
  end

  assign busy = (remain != '0);

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remain == FULL); // R8
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && remain != '0) |=> remain == $past(remain) - 1'b1); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && remain == '0) |=> remain == '0); // R4
endmodule

// File: rtl/manual_reset_timer.sv
module manual_reset_timer #(
  parameter longint TIMEOUT_CYCLES = 10_000_000,
  parameter int     SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_high,
  input  logic man_in,
  output logic rst_out,
  output logic rst_out_n,
  output logic mem_block
);
  import mrt_pkg::*;

  logic act_raw;
  logic act_sync;
  logic fire;
  logic busy;

  assign act_raw = active_level(man_in, pol_high);

  mrt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (act_raw),
    .dout (act_sync)
  );

  mrt_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (act_sync),
    .fire (fire)
  );

  mrt_timer #(.TIMEOUT(TIMEOUT_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (fire),
    .busy (busy)
  );

  assign rst_out   = busy;
  assign rst_out_n = ~busy;
  assign mem_block = busy | act_sync;

  AST_RISE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(fire)); // R2
endmodule

// File: tb/manual_reset_timer_tb.sv
module manual_reset_timer_tb;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_high = 1'b1;
  logic man_in = 1'b0;
  logic rst_out, rst_out_n, mem_block;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  manual_reset_timer #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pol_high(pol_high), .man_in(man_in),
    .rst_out(rst_out), .rst_out_n(rst_out_n), .mem_block(mem_block)
  );

  // Behavioural reference: history of active levels seen at rising edges
  // plus a remaining-cycle integer.
  int  seen[$] = '{0, 0, 0};
  int  left    = T;
  bit  model_ok = 1'b0;

  always @(posedge clk) begin
    int a;
    a = pol_high ? int'(man_in) : int'(!man_in);
    if (!rst_n) begin
      seen = '{0, 0, 0};
      left = T;
    end else begin
      if (seen[1] == 1 && seen[2] == 0) left = T;
      else if (left > 0) left = left - 1;
      seen.push_front(a);
      void'(seen.pop_back());
    end
    model_ok = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the edge.
  always @(posedge clk) begin
    #5;
    if (model_ok && !done) begin
      check(rst_out === (left > 0), "R2 rst_out vs model", int'(rst_out), int'(left > 0));
      check(rst_out_n === !rst_out, "R5 complement", int'(rst_out_n), int'(!rst_out));
      check(mem_block === (left > 0 || seen[1] == 1), "R7 mem_block vs model",
            int'(mem_block), int'(left > 0 || seen[1] == 1));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called just after driving the active level at a negedge.
  task automatic measure(output int lat, output int width);
    lat = 0; width = 0;
    while (rst_out !== 1'b1 && lat < 10) begin
      @(posedge clk); #5; lat++;
    end
    while (rst_out === 1'b1 && width < 4 * T) begin
      width++;
      @(posedge clk); #5;
    end
    @(negedge clk);
  endtask

  task automatic power_on(input logic pol, input logic idle);
    @(negedge clk);
    pol_high = pol;
    man_in   = idle;
    rst_n    = 1'b0;
    cycles(3);
  endtask

  initial begin
    int lat, w, hi;
    // R1: power-on state and first release
    cycles(2);
    @(posedge clk); #5;
    check(rst_out === 1'b1 && rst_out_n === 1'b0 && mem_block === 1'b1,
          "R1 outputs during reset", int'(rst_out), 1);
    @(negedge clk);
    rst_n = 1'b1;
    hi = 0;
    repeat (T + 5) begin
      @(posedge clk); #5;
      if (rst_out === 1'b1) hi++;
    end
    check(hi == T - 1, "R1 power-on pulse samples", hi, T - 1);
    check(rst_out === 1'b0 && mem_block === 1'b0, "R1 released idle", int'(rst_out), 0);
    @(negedge clk);

    // R2: short rising press, active-high
    man_in = 1'b1;
    fork
      begin cycles(3); man_in = 1'b0; end
      measure(lat, w);
    join
    check(lat == 3, "R2 latency", lat, 3);
    check(w == T, "R2 width", w, T);

    // R4: release and steady level start nothing
    cycles(30);
    check(rst_out === 1'b0 && mem_block === 1'b0, "R4 idle after release", int'(rst_out), 0);

    // R6/R7: hold well past the timeout
    man_in = 1'b1;
    fork
      begin cycles(2 * T + 10); man_in = 1'b0; end
      begin
        measure(lat, w);
        check(w == T, "R6 width with held input", w, T);
        check(mem_block === 1'b1 && rst_out === 1'b0, "R7 held input blocks memory",
              int'(mem_block), 1);
      end
    join
    cycles(3);
    check(mem_block === 1'b0 && rst_out === 1'b0, "R7 block ends after release",
          int'(mem_block), 0);
    check(rst_out === 1'b0, "R4 release does not trigger", int'(rst_out), 0);

    // R8: retrigger during a running pulse
    cycles(5);
    man_in = 1'b1;
    cycles(2);
    man_in = 1'b0;
    cycles(8);
    man_in = 1'b1;
    w = 0;
    @(posedge clk); #5;
    while (rst_out === 1'b1 && w < 4 * T) begin
      w++;
      @(posedge clk); #5;
    end
    check(w == T + 2, "R8 restart extends pulse", w, T + 2);
    @(negedge clk);
    man_in = 1'b0;
    cycles(10);

    // R3: active-low polarity
    power_on(1'b0, 1'b1);
    rst_n = 1'b1;
    cycles(T + 5);
    check(rst_out === 1'b0, "R1 power-on release, low polarity", int'(rst_out), 0);
    man_in = 1'b0;
    fork
      begin cycles(3); man_in = 1'b1; end
      measure(lat, w);
    join
    check(lat == 3, "R3 latency", lat, 3);
    check(w == T, "R3 width", w, T);
    cycles(25);
    check(rst_out === 1'b0 && mem_block === 1'b0, "R4 rising edge ignored, low polarity",
          int'(rst_out), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule